// File: doc/BRIEF.md
# Parallel Camera Sensor Capture

This block sits at the edge of an image pipeline and turns a parallel image-sensor bus into a clean pixel stream. The bus has a vertical sync, a horizontal sync, a data word of up to ten bits and a pixel clock. The block runs directly on that pixel clock, and every rising edge is one sampling opportunity. Each accepted word leaves the block with a valid strobe, a start-of-frame marker, an end-of-line marker, and its column and row position within the frame. The stream goes to an input FIFO downstream.

Two qualification schemes are chosen by a static input. In gated operation the horizontal sync is high for the whole active line, and only clock edges inside that window carry data. The falling edge of horizontal sync closes the line. To mark the last pixel of a line, the block holds back each pixel until it knows whether another pixel follows. In free-running operation the horizontal sync plays no part. Every clock edge after a frame start delivers a word, and the data is cut to its lower eight bits. Two further static inputs invert either sync before edge detection, so sensors with active-low syncs can be attached.

Top module: `cam_capture`

## Requirements
- R1: A frame starts on a clock edge where the polarity-corrected vertical sync is high after being low on the previous edge. A vertical sync that is already high when reset ends does not count as a frame start. No pixel is emitted after reset until the first frame start.
- R2: When `vsync_inv` is 1, the block treats vertical sync as active-low. When `hsync_inv` is 1, it treats horizontal sync as active-low. The inversion is applied before any edge detection.
- R3: In gated mode (`gated_mode`=1), a clock edge while the corrected horizontal sync is high captures `data_in` as a pixel. An edge while it is low captures nothing. All `DATA_W` bits of the word pass through unchanged.
- R4: The first pixel emitted after a frame start has `px_sof`=1, `px_col`=0 and `px_row`=0. Every other pixel has `px_sof`=0.
- R5: In gated mode, each pixel is emitted on the edge of the next captured pixel of its line. The last pixel of a line is emitted with `px_eol`=1 on the edge where the corrected horizontal sync falls. No pixel is emitted on the edge that follows an end-of-line.
- R6: `px_col` counts pixels from 0 within a line. `px_row` counts lines from 0 within a frame and advances on each horizontal sync fall in gated mode. Both counters restart at a frame start.
- R7: In free-running mode (`gated_mode`=0), every edge after a frame start emits the word sampled on that edge, on the following cycle. Horizontal sync is ignored, `px_eol` stays 0 and `px_row` stays 0.
- R8: In free-running mode, bits `DATA_W-1` down to `NARROW_W` of `px_data` are 0 (bits 9:8 with the defaults).
- R9: A change of `gated_mode` disarms capture. No pixel is emitted until the next frame start.
- R10: A frame start drops any pixel still held back without emitting it, and it emits nothing on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Sensor pixel clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| vsync_in | input | 1 | Vertical sync from the sensor |
| hsync_in | input | 1 | Horizontal sync from the sensor |
| data_in | input | DATA_W | Sensor data word |
| gated_mode | input | 1 | 1 = horizontal sync qualifies pixels, 0 = every edge after frame start is a pixel |
| vsync_inv | input | 1 | Treat vertical sync as active-low |
| hsync_inv | input | 1 | Treat horizontal sync as active-low |
| px_valid | output | 1 | Output pixel strobe |
| px_data | output | DATA_W | Output pixel word |
| px_sof | output | 1 | First pixel of a frame |
| px_eol | output | 1 | Last pixel of a line (gated mode) |
| px_col | output | COUNT_W | Pixel index within the line |
| px_row | output | COUNT_W | Line index within the frame |

## Verification
The bench goes after the points where capture starts and stops. Three stimuli all must yield nothing: line traffic before any vertical sync, a mode switch with no new frame start, and a vertical sync that cuts a line short. A design that armed too early or failed to flush would emit stray pixels, or a held pixel carrying a false end-of-line. Whole frames of several sizes, with both sync polarities, are compared word by word against arithmetic patterns. A wrong hold-back would misplace `px_eol` or drop the last pixel of each line, and a counter that failed to restart would show up in `px_col` and `px_row`. The free-running sweep toggles horizontal sync and drives the top data bits high, so any leak of either shows up in the output.

// File: rtl/cam_pkg.sv
package cam_pkg;
   // Qualification scheme selected by the static mode input.
   typedef enum logic {
      QUAL_FREE  = 1'b0,
      QUAL_GATED = 1'b1
   } qual_mode_e;
endpackage

// File: rtl/cam_sync_edge.sv
// Polarity correction of one sync input plus a registered copy of the
// corrected level for edge detection in the parent.
module cam_sync_edge #(
   parameter bit IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_raw,
   input  logic invert,
   output logic lvl,
   output logic lvl_q
);
   assign lvl = sig_raw ^ invert;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE_LVL;
      else        lvl_q <= lvl;
   end
endmodule

// File: rtl/cam_data_mask.sv
// Clears the bits above the narrow bus width when narrow is set.
module cam_data_mask #(
   parameter int DATA_W   = 10,
   parameter int NARROW_W = 8
) (
   input  logic              narrow,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   if (DATA_W > NARROW_W) begin : g_cut
      localparam int HI_W = DATA_W - NARROW_W;
      assign dout = narrow ? {{HI_W{1'b0}}, din[NARROW_W-1:0]} : din;
   end else begin : g_pass
      logic unused_narrow;
      assign unused_narrow = narrow;
      assign dout = din;
   end
endmodule

// File: rtl/cam_emit.sv
// Output stage: direct register in free-running mode, one-pixel hold-back
// in gated mode so the last pixel of a line can carry end-of-line.
module cam_emit #(
   parameter int DATA_W  = 10,
   parameter int COUNT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               gated,
   input  logic               flush,
   input  logic               take,
   input  logic               close,
   input  logic [DATA_W-1:0]  in_data,
   input  logic               in_sof,
   input  logic [COUNT_W-1:0] in_col,
   input  logic [COUNT_W-1:0] in_row,
   output logic               out_valid,
   output logic [DATA_W-1:0]  out_data,
   output logic               out_sof,
   output logic               out_eol,
   output logic [COUNT_W-1:0] out_col,
   output logic [COUNT_W-1:0] out_row
);
   logic               hold_vld;
   logic [DATA_W-1:0]  hold_data;
   logic               hold_sof;
   logic [COUNT_W-1:0] hold_col;
   logic [COUNT_W-1:0] hold_row;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_vld  <= 1'b0;
         hold_data <= '0;
         hold_sof  <= 1'b0;
         hold_col  <= '0;
         hold_row  <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         out_col   <= '0;
         out_row   <= '0;
      end else begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_eol   <= 1'b0;
         if (flush) begin
            hold_vld <= 1'b0;
         end else if (!gated) begin
            if (take) begin
               out_valid <= 1'b1;
               out_data  <= in_data;
               out_sof   <= in_sof;
               out_col   <= in_col;
               out_row   <= in_row;
            end
         end else if (take) begin
            if (hold_vld) begin
               out_valid <= 1'b1;
               out_data  <= hold_data;
               out_sof   <= hold_sof;
               out_col   <= hold_col;
               out_row   <= hold_row;
            end
            hold_vld  <= 1'b1;
            hold_data <= in_data;
            hold_sof  <= in_sof;
            hold_col  <= in_col;
            hold_row  <= in_row;
         end else if (close) begin
            if (hold_vld) begin
               out_valid <= 1'b1;
               out_eol   <= 1'b1;
               out_data  <= hold_data;
               out_sof   <= hold_sof;
               out_col   <= hold_col;
               out_row   <= hold_row;
            end
            hold_vld <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cam_capture.sv
module cam_capture
   import cam_pkg::*;
#(
   parameter int DATA_W   = 10,
   parameter int NARROW_W = 8,
   parameter int COUNT_W  = 12
) (
   input  logic               clk_pix,
   input  logic               rst_n,
   input  logic               vsync_in,
   input  logic               hsync_in,
   input  logic [DATA_W-1:0]  data_in,
   input  logic               gated_mode,
   input  logic               vsync_inv,
   input  logic               hsync_inv,
   output logic               px_valid,
   output logic [DATA_W-1:0]  px_data,
   output logic               px_sof,
   output logic               px_eol,
   output logic [COUNT_W-1:0] px_col,
   output logic [COUNT_W-1:0] px_row
);
   localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

   if (NARROW_W < 1 || NARROW_W > DATA_W) begin : g_bad_narrow
      $error("cam_capture: NARROW_W must lie in 1..DATA_W");
   end
   if (COUNT_W < 2) begin : g_bad_count
      $error("cam_capture: COUNT_W must be at least 2");
   end

   // Sync conditioning. Vertical sync idles "seen high" so a level already
   // active when reset ends is not taken as a frame start.
   logic vs_lvl, vs_q, hs_lvl, hs_q;

   cam_sync_edge #(.IDLE_LVL(1'b1)) u_vs (
      .clk(clk_pix), .rst_n(rst_n), .sig_raw(vsync_in), .invert(vsync_inv),
      .lvl(vs_lvl), .lvl_q(vs_q)
   );
   cam_sync_edge #(.IDLE_LVL(1'b0)) u_hs (
      .clk(clk_pix), .rst_n(rst_n), .sig_raw(hsync_in), .invert(hsync_inv),
      .lvl(hs_lvl), .lvl_q(hs_q)
   );

   qual_mode_e mode_now, mode_q;
   assign mode_now = qual_mode_e'(gated_mode);

   logic frame_start, mode_chg, is_gated, armed, sof_pend;
   logic take, close, flush;
   logic [COUNT_W-1:0] col_cnt, row_cnt;
   logic [DATA_W-1:0]  data_m;

   assign frame_start = vs_lvl & ~vs_q;
   assign mode_chg    = (mode_now != mode_q);
   assign is_gated    = (mode_now == QUAL_GATED);
   assign flush       = frame_start | mode_chg;
   assign take        = armed & ~flush & (is_gated ? hs_lvl : 1'b1);
   assign close       = armed & ~flush & is_gated & hs_q & ~hs_lvl;

   always_ff @(posedge clk_pix or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= QUAL_FREE;
         armed    <= 1'b0;
         sof_pend <= 1'b0;
         col_cnt  <= '0;
         row_cnt  <= '0;
      end else begin
         mode_q <= mode_now;
         if (mode_chg)         armed <= 1'b0;
         else if (frame_start) armed <= 1'b1;

         if (frame_start) begin
            sof_pend <= 1'b1;
            col_cnt  <= '0;
            row_cnt  <= '0;
         end else if (take) begin
            sof_pend <= 1'b0;
            col_cnt  <= col_cnt + CNT_ONE;
         end else if (close) begin
            col_cnt  <= '0;
            row_cnt  <= row_cnt + CNT_ONE;
         end
      end
   end

   cam_data_mask #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_mask (
      .narrow(~is_gated), .din(data_in), .dout(data_m)
   );

   cam_emit #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_emit (
      .clk(clk_pix), .rst_n(rst_n), .gated(is_gated), .flush(flush),
      .take(take), .close(close), .in_data(data_m), .in_sof(sof_pend),
      .in_col(col_cnt), .in_row(row_cnt),
      .out_valid(px_valid), .out_data(px_data), .out_sof(px_sof),
      .out_eol(px_eol), .out_col(px_col), .out_row(px_row)
   );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
   parameter int DATA_W   = 10,
   parameter int NARROW_W = 8,
   parameter int COUNT_W  = 12
) (
   input logic               clk_pix,
   input logic               rst_n,
   input logic               gated_mode,
   input logic               px_valid,
   input logic [DATA_W-1:0]  px_data,
   input logic               px_sof,
   input logic               px_eol,
   input logic [COUNT_W-1:0] px_col,
   input logic [COUNT_W-1:0] px_row
);
   assert_sof_origin_R4: assert property (@(posedge clk_pix) disable iff (!rst_n)
      px_sof |-> (px_valid && px_col == '0 && px_row == '0));

   assert_eol_only_gated_R7: assert property (@(posedge clk_pix) disable iff (!rst_n)
      px_eol |-> (px_valid && gated_mode));

   assert_free_row_zero_R7: assert property (@(posedge clk_pix) disable iff (!rst_n)
      (px_valid && !gated_mode) |-> (px_row == '0));

   assert_narrow_bits_R8: assert property (@(posedge clk_pix) disable iff (!rst_n)
      (px_valid && !gated_mode) |-> ((px_data >> NARROW_W) == '0));

   assert_gap_after_eol_R5: assert property (@(posedge clk_pix) disable iff (!rst_n)
      px_eol |=> !px_valid);

   assert_col_step_R6: assert property (@(posedge clk_pix) disable iff (!rst_n)
      (px_valid && !px_sof && $past(px_valid) && !$past(px_eol) && $stable(gated_mode))
      |-> (px_col == COUNT_W'($past(px_col) + 1'b1) && px_row == $past(px_row)));
endmodule

bind cam_capture cam_capture_chk #(
   .DATA_W(DATA_W), .NARROW_W(NARROW_W), .COUNT_W(COUNT_W)
) u_chk (
   .clk_pix(clk_pix), .rst_n(rst_n), .gated_mode(gated_mode),
   .px_valid(px_valid), .px_data(px_data), .px_sof(px_sof), .px_eol(px_eol),
   .px_col(px_col), .px_row(px_row)
);

// File: tb/cam_capture_bench.sv
module cam_capture_bench;
   localparam int DW = 10;
   localparam int CW = 12;
   localparam int MAXE = 128;

   logic          clk_pix = 1'b0;
   logic          rst_n;
   logic          vsync_in, hsync_in, gated_mode, vsync_inv, hsync_inv;
   logic [DW-1:0] data_in;
   logic          px_valid, px_sof, px_eol;
   logic [DW-1:0] px_data;
   logic [CW-1:0] px_col, px_row;

   always #10 clk_pix = ~clk_pix;

   cam_capture #(.DATA_W(DW), .NARROW_W(8), .COUNT_W(CW)) u_cam_capture (
      .clk_pix(clk_pix), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
      .data_in(data_in), .gated_mode(gated_mode), .vsync_inv(vsync_inv),
      .hsync_inv(hsync_inv), .px_valid(px_valid), .px_data(px_data),
      .px_sof(px_sof), .px_eol(px_eol), .px_col(px_col), .px_row(px_row)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   // recorded and expected event lists
   logic [DW-1:0] r_data [MAXE];
   logic          r_sof  [MAXE];
   logic          r_eol  [MAXE];
   logic [CW-1:0] r_col  [MAXE];
   logic [CW-1:0] r_row  [MAXE];
   int            r_n = 0;
   logic [DW-1:0] e_data [MAXE];
   logic          e_sof  [MAXE];
   logic          e_eol  [MAXE];
   logic [CW-1:0] e_col  [MAXE];
   logic [CW-1:0] e_row  [MAXE];
   int            e_n = 0;

   always @(negedge clk_pix) begin
      if (rst_n === 1'b1 && px_valid === 1'b1 && r_n < MAXE) begin
         r_data[r_n] = px_data;
         r_sof[r_n]  = px_sof;
         r_eol[r_n]  = px_eol;
         r_col[r_n]  = px_col;
         r_row[r_n]  = px_row;
         r_n = r_n + 1;
      end
   end

   function automatic logic [DW-1:0] pat(int seed, int l, int p);
      return DW'(seed + l * 37 + p * 5 + (p << 7));
   endfunction

   task automatic push(logic [DW-1:0] d, logic s, logic e, int c, int r);
      e_data[e_n] = d; e_sof[e_n] = s; e_eol[e_n] = e;
      e_col[e_n] = CW'(c); e_row[e_n] = CW'(r);
      e_n = e_n + 1;
   endtask

   task automatic clear_lists();
      @(negedge clk_pix);
      r_n = 0;
      e_n = 0;
   endtask

   // drive logical sync levels; physical level includes the bench's polarity
   task automatic drive(logic vs, logic hs, logic [DW-1:0] d);
      @(negedge clk_pix);
      vsync_in = vs ^ vsync_inv;
      hsync_in = hs ^ hsync_inv;
      data_in  = d;
   endtask

   task automatic compare(string req);
      repeat (3) drive(1'b0, 1'b0, '0);
      checks++;
      if (r_n != e_n) begin
         errors++;
         $display("FAIL %s: event count actual %0d expected %0d", req, r_n, e_n);
      end
      for (int i = 0; i < e_n && i < r_n; i++) begin
         checks++;
         if (r_data[i] !== e_data[i] || r_sof[i] !== e_sof[i] || r_eol[i] !== e_eol[i] ||
             r_col[i] !== e_col[i] || r_row[i] !== e_row[i]) begin
            errors++;
            $display("FAIL %s: event %0d actual d=%h sof=%b eol=%b col=%0d row=%0d expected d=%h sof=%b eol=%b col=%0d row=%0d",
                     req, i, r_data[i], r_sof[i], r_eol[i], r_col[i], r_row[i],
                     e_data[i], e_sof[i], e_eol[i], e_col[i], e_row[i]);
         end
      end
   endtask

   // gated frame: W pixels per line, L lines
   task automatic gated_frame(int w, int l, int seed, bit expect_it);
      drive(1'b1, 1'b0, '0);
      drive(1'b1, 1'b0, '0);
      drive(1'b0, 1'b0, '0);
      drive(1'b0, 1'b0, '0);
      for (int li = 0; li < l; li++) begin
         for (int p = 0; p < w; p++) begin
            drive(1'b0, 1'b1, pat(seed, li, p));
            if (expect_it) push(pat(seed, li, p), li == 0 && p == 0, p == w - 1, p, li);
         end
         repeat (3) drive(1'b0, 1'b0, '0);
      end
   endtask

   task automatic apply_reset(logic vi, logic hi);
      @(negedge clk_pix);
      rst_n = 1'b0;
      vsync_inv = vi;
      hsync_inv = hi;
      vsync_in = vi;
      hsync_in = hi;
      data_in = '0;
      repeat (2) @(negedge clk_pix);
      rst_n = 1'b1;
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      rst_n = 1'b0;
      gated_mode = 1'b1;
      vsync_inv = 1'b0;
      hsync_inv = 1'b0;
      vsync_in = 1'b1;   // high across reset: must not count as frame start
      hsync_in = 1'b0;
      data_in = '0;
      repeat (3) @(negedge clk_pix);
      checks++;
      if (px_valid !== 1'b0 || px_sof !== 1'b0 || px_eol !== 1'b0 ||
          px_col !== '0 || px_row !== '0 || px_data !== '0) begin
         errors++;
         $display("FAIL R1: reset outputs actual v=%b sof=%b eol=%b col=%0d row=%0d expected all zero",
                  px_valid, px_sof, px_eol, px_col, px_row);
      end
      rst_n = 1'b1;

      // R1: line traffic before any frame start, vsync held high from reset
      clear_lists();
      for (int l = 0; l < 2; l++) begin
         for (int p = 0; p < 4; p++) drive(1'b1, 1'b1, pat(3, l, p));
         repeat (2) drive(1'b1, 1'b0, '0);
      end
      compare("R1");

      // R3 R4 R5 R6: gated frames of two sizes
      clear_lists();
      gated_frame(4, 3, 11, 1'b1);
      compare("R3_R5");
      clear_lists();
      gated_frame(6, 2, 400, 1'b1);
      gated_frame(1, 2, 77, 1'b1);
      compare("R4_R6");

      // R2: inverted sync polarity
      apply_reset(1'b1, 1'b1);
      clear_lists();
      gated_frame(3, 2, 250, 1'b1);
      compare("R2");

      // R10: frame start cuts a line short; held pixel dropped
      clear_lists();
      gated_frame(0, 0, 0, 1'b0);
      for (int p = 0; p < 3; p++) begin
         drive(1'b0, 1'b1, pat(9, 0, p));
         if (p < 2) push(pat(9, 0, p), p == 0, 1'b0, p, 0);
      end
      gated_frame(2, 1, 600, 1'b1);
      compare("R10");

      // R9: switch to free-running, no frame start yet -> nothing
      apply_reset(1'b0, 1'b0);
      clear_lists();
      gated_frame(2, 1, 5, 1'b1);
      gated_mode = 1'b0;
      for (int p = 0; p < 5; p++) drive(1'b0, p[0], pat(1, 0, p));
      compare("R9");

      // R7 R8: free-running frame, hsync toggling, upper bits set
      clear_lists();
      drive(1'b0, 1'b0, '0);
      drive(1'b1, 1'b1, 10'h3FF);
      for (int p = 0; p < 12; p++) begin
         drive(p < 3, p[1], pat(21, 0, p) | 10'h300);
         push(pat(21, 0, p) & 10'h0FF, p == 0, 1'b0, p, 0);
      end
      @(negedge clk_pix);
      gated_mode = 1'b1;
      vsync_in = 1'b0;
      hsync_in = 1'b0;
      compare("R7_R8");

      // R9: back to gated without a frame start -> nothing, then a frame works
      clear_lists();
      for (int l = 0; l < 2; l++) begin
         for (int p = 0; p < 3; p++) drive(1'b0, 1'b1, pat(8, l, p));
         repeat (2) drive(1'b0, 1'b0, '0);
      end
      gated_frame(3, 1, 90, 1'b1);
      compare("R9_R3");

      done = 1;
      report();
   end

   initial begin
      repeat (100000) @(posedge clk_pix);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected completion");
         report();
      end
   end
endmodule